// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer with a single control register. It counts down on a slow tick-enable input. While it is enabled, software can only rewrite the control register by presenting a 7-bit key that is the bitwise complement of the key already stored. Any write without that key is dropped, so a runaway program that writes a fixed pattern cannot keep the watchdog alive.

Expiry escalates in two steps. On the first expiry the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before software services the watchdog, the block raises a reset request. The request stays high until the block itself is reset. Driving the reset of the rest of the system is left to the logic that consumes the request.

A status register gives back the live count and whether an expiry has happened since the last accepted write.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the watchdog is stopped, and both `nmi` and `reset_req` are low.
- R2: The control register is at offset 0x40 and reads back the last accepted value, with the key in [15:9], the run command in bit 8 and the reload count in [7:0]. The status register is at offset 0x44 and holds the current count in [8:0] and the expiry flag in bit 9. All other offsets read 0.
- R3: While bit 8 of the stored control value is 0 (disabled), every write to 0x40 is accepted, whatever its key.
- R4: While bit 8 of the stored control value is 1 (enabled), a write to 0x40 is accepted only if its [15:9] equals the bitwise complement of the stored [15:9]. A rejected write changes neither the control value, the count nor the outputs.
- R5: A reload count field of 0 loads a count of 256.
- R6: An accepted write loads the count. If bit 8 is 1, the count then drops by one on each cycle with `tick_en` high. If bit 8 is 0, the count holds.
- R7: The first expiry (a tick while the count is 1) raises `nmi` in the next cycle, sets the expiry flag and reloads the grace count (parameter, default 1) while the count keeps running.
- R8: An expiry while the expiry flag is already set raises `reset_req`, leaves the count at 0 and stops it.
- R9: An accepted write drops `nmi` and clears the expiry flag.
- R10: Once `reset_req` is high, it stays high until `rst_n` is asserted, and accepted writes do not clear it.
- R11: When an accepted write and a tick fall in the same cycle, the write wins and the tick has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Countdown enable, one pulse per watchdog tick |
| nmi | output | 1 | Non-maskable interrupt after the first expiry |
| reset_req | output | 1 | Sticky system reset request after the second expiry |

## Verification
The hardest state to reach from the ports is the second expiry. It needs an enabled watchdog whose key chain has stayed intact, a short count, and enough ticks to run through both the count and the grace period with no accepted write in between. Random writes would usually break the key chain or service the counter first. The stimulus therefore picks small reload counts, presents the correct complemented key most of the time, and resets the block between random episodes. This keeps driving the block back into the escalation path. A bench model that follows the requirements is compared against both registers and both outputs on every cycle. Directed cases cover the zero-means-256 load, a write that coincides with a tick, and the request staying high across accepted writes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned KEY_W       = 7;
  localparam int unsigned CNT_FIELD_W = 8;
  localparam int unsigned RUN_BIT     = CNT_FIELD_W;
  localparam int unsigned KEY_LSB     = CNT_FIELD_W + 1;
  localparam int unsigned CTRL_W      = KEY_LSB + KEY_W;
  localparam int unsigned CNT_W       = CNT_FIELD_W + 1;

  typedef enum logic [1:0] {
    ESC_CLEAN   = 2'd0,
    ESC_WARNED  = 2'd1,
    ESC_TRIPPED = 2'd2
  } esc_state_e;

  // Field value to tick count: a zero field stands for the full range.
  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_FIELD_W-1:0] field);
    return (field == '0) ? {1'b1, {CNT_FIELD_W{1'b0}}} : {1'b0, field};
  endfunction

  // Key rule: free while disabled, complement of the stored key while enabled.
  function automatic logic key_ok(input logic enabled,
                                  input logic [KEY_W-1:0] stored,
                                  input logic [KEY_W-1:0] offered);
    return !enabled || (offered == ~stored);
  endfunction

endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_val,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              accept
);

  logic             enabled;
  logic [KEY_W-1:0] stored_key;
  logic [KEY_W-1:0] offered_key;

  assign enabled     = ctrl_q[RUN_BIT];
  assign stored_key  = ctrl_q[KEY_LSB +: KEY_W];
  assign offered_key = wr_val[KEY_LSB +: KEY_W];
  assign accept      = wr_ctrl && key_ok(enabled, stored_key, offered_key);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_val;
  end

  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && enabled && (offered_key != ~stored_key)) |=> $stable(ctrl_q)); // R4
  AST_FREE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !enabled) |=> (ctrl_q == $past(wr_val))); // R3

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_run,
  input  logic             tick,
  input  logic             grace_load,
  input  logic             halt,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);

  localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);

  // A load takes the cycle; a tick that coincides with it is dropped.
  assign expire = running && tick && (count == CNT_W'(1)) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= load_run;
    end else if (grace_load) begin
      count   <= GRACE_VAL;
    end else if (halt) begin
      count   <= '0;
      running <= 1'b0;
    end else if (running && tick) begin
      count   <= count - CNT_W'(1);
    end
  end

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count != '0)); // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(count)); // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !load && (count > CNT_W'(1))) |=> (count == $past(count) - CNT_W'(1))); // R6
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !load) |=> $stable(count)); // R6

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic expire,
  output logic grace_load,
  output logic halt,
  output logic expired,
  output logic nmi,
  output logic reset_req
);

  esc_state_e state_q;

  assign grace_load = expire && (state_q == ESC_CLEAN);
  assign halt       = expire && (state_q != ESC_CLEAN);
  assign expired    = (state_q != ESC_CLEAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ESC_CLEAN;
      nmi       <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (accept) begin
        state_q <= ESC_CLEAN;
        nmi     <= 1'b0;
      end else if (grace_load) begin
        state_q <= ESC_WARNED;
        nmi     <= 1'b1;
      end else if (halt) begin
        state_q <= ESC_TRIPPED;
      end
      if (halt) reset_req <= 1'b1;
    end
  end

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !expired) |=> (nmi && expired)); // R7
  AST_RESET_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && expired) |=> reset_req); // R8
  AST_RESET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req); // R10
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!nmi && !expired)); // R9
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && expire)); // R11

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CTRL_OFS    = 'h40,
  parameter int unsigned STAT_OFS    = 'h44,
  parameter int unsigned GRACE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  output logic              nmi,
  output logic              reset_req
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  // Named internal events shared by the submodules and the assertions.
  logic              sel_ctrl;
  logic              sel_stat;
  logic              wr_ctrl;
  logic [CTRL_W-1:0] wr_val;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_accept;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_running;
  logic              cnt_expire;
  logic              esc_grace;
  logic              esc_halt;
  logic              esc_expired;

  assign sel_ctrl = (bus_addr == CTRL_A);
  assign sel_stat = (bus_addr == STAT_A);
  assign wr_ctrl  = bus_wr && sel_ctrl;
  assign wr_val   = bus_wdata[CTRL_W-1:0];

  wdg_key_gate u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wr_val (wr_val),
    .ctrl_q (ctrl_q),
    .accept (ctrl_accept)
  );

  wdg_countdown #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctrl_accept),
    .load_val  (reload_of(wr_val[CNT_FIELD_W-1:0])),
    .load_run  (wr_val[RUN_BIT]),
    .tick      (tick_en),
    .grace_load(esc_grace),
    .halt      (esc_halt),
    .count     (cnt_q),
    .running   (cnt_running),
    .expire    (cnt_expire)
  );

  wdg_escalate u_esc (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ctrl_accept),
    .expire    (cnt_expire),
    .grace_load(esc_grace),
    .halt      (esc_halt),
    .expired   (esc_expired),
    .nmi       (nmi),
    .reset_req (reset_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = DATA_W'(ctrl_q);
    else if (sel_stat) bus_rdata = DATA_W'({esc_expired, cnt_q});
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> (cnt_q == reload_of($past(wr_val[CNT_FIELD_W-1:0])))); // R5
  AST_LOAD_RUNSTATE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> (cnt_running == $past(wr_val[RUN_BIT]))); // R11
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[RUN_BIT]) |-> !cnt_running); // R6

endmodule

// File: tb/wdg_keyed_top_tb_top.sv
module wdg_keyed_top_tb_top;

  localparam int GRACE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        nmi;
  logic        reset_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model of the requirements.
  logic [15:0] m_ctrl;
  int          m_cnt;
  bit          m_run;
  int          m_hits;
  bit          m_nmi;
  bit          m_rst;

  always #10 clk = ~clk;

  wdg_keyed_top #(.GRACE_TICKS(GRACE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .nmi(nmi), .reset_req(reset_req)
  );

  function automatic int reload_cnt(input logic [7:0] f);
    return (f == 8'd0) ? 256 : int'(f);
  endfunction

  function automatic bit key_pass(input logic [15:0] stored, input logic [15:0] wv);
    if (!stored[8]) return 1'b1;
    return wv[15:9] == (~stored[15:9]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 16'h0; m_cnt = 0; m_run = 0; m_hits = 0; m_nmi = 0; m_rst = 0;
  endtask

  task automatic model_step(input bit wr, input logic [7:0] a,
                            input logic [15:0] d, input bit tk);
    if (wr && a == 8'h40 && key_pass(m_ctrl, d)) begin
      m_ctrl = d; m_cnt = reload_cnt(d[7:0]); m_run = d[8]; m_hits = 0; m_nmi = 0;
    end else if (m_run && tk) begin
      if (m_cnt > 1) m_cnt--;
      else if (m_hits == 0) begin m_cnt = GRACE; m_hits = 1; m_nmi = 1; end
      else begin m_cnt = 0; m_run = 0; m_hits = 2; m_rst = 1; end
    end
  endtask

  task automatic compare_all();
    logic [15:0] st, ct;
    bus_addr = 8'h44; #1; st = bus_rdata;
    bus_addr = 8'h40; #1; ct = bus_rdata;
    chk(st[8:0] == m_cnt[8:0], "R6", "count", int'(st[8:0]), m_cnt);
    chk(st[9] == (m_hits != 0), "R7", "expiry flag", int'(st[9]), int'(m_hits != 0));
    chk(ct == m_ctrl, "R4", "control", int'(ct), int'(m_ctrl));
    chk(nmi == m_nmi, "R7", "nmi", int'(nmi), int'(m_nmi));
    chk(reset_req == m_rst, "R10", "reset_req", int'(reset_req), int'(m_rst));
  endtask

  // Called at a negedge; applies one cycle of stimulus and compares.
  task automatic step(input bit wr, input logic [7:0] a, input logic [15:0] d, input bit tk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    model_step(wr, a, d, tk);
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic logic [15:0] wval(input logic [6:0] k, input bit run, input logic [7:0] c);
    return {k, run, c};
  endfunction

  task automatic status_is(input int cnt, input string req);
    bus_addr = 8'h44; #1;
    chk(bus_rdata[8:0] == cnt[8:0], req, "status count", int'(bus_rdata[8:0]), cnt);
  endtask

  initial begin
    process::self().srandom(32'h5eed_0017);
    @(negedge clk);
    do_reset();
    // R1: reset state
    bus_addr = 8'h40; #1;
    chk(bus_rdata == 16'h0, "R1", "control after reset", int'(bus_rdata), 0);
    bus_addr = 8'h44; #1;
    chk(bus_rdata == 16'h0, "R1", "status after reset", int'(bus_rdata), 0);
    chk(!nmi && !reset_req, "R1", "outputs after reset", int'({nmi, reset_req}), 0);

    // R3: disabled accepts any key; R2 field readback
    step(1, 8'h40, wval(7'h15, 1, 8'd3), 0);
    bus_addr = 8'h40; #1;
    chk(bus_rdata == 16'h2B03, "R2", "control fields", int'(bus_rdata), 16'h2B03);
    status_is(3, "R3");
    step(0, 8'h40, 16'h0, 1);
    status_is(2, "R6");
    // R4: same key again while enabled is rejected
    step(1, 8'h40, wval(7'h15, 1, 8'd9), 0);
    status_is(2, "R4");
    // R11: correct key together with a tick
    step(1, 8'h40, wval(7'h6A, 1, 8'd5), 1);
    status_is(5, "R11");
    for (int i = 0; i < 4; i++) step(0, 8'h40, 16'h0, 1);
    step(0, 8'h40, 16'h0, 0);
    status_is(1, "R6");
    step(0, 8'h40, 16'h0, 1);
    chk(nmi == 1'b1, "R7", "nmi after first expiry", int'(nmi), 1);
    status_is(GRACE, "R7");
    step(0, 8'h40, 16'h0, 1);
    chk(reset_req == 1'b1, "R8", "reset_req after second expiry", int'(reset_req), 1);
    status_is(0, "R8");
    // R9/R10/R5: service after trip, zero field, stopped
    step(1, 8'h40, wval(7'h15, 0, 8'd0), 0);
    chk(nmi == 1'b0, "R9", "nmi after service", int'(nmi), 0);
    chk(reset_req == 1'b1, "R10", "reset_req sticky", int'(reset_req), 1);
    status_is(256, "R5");
    step(0, 8'h40, 16'h0, 1);
    status_is(256, "R6");
    bus_addr = 8'h10; #1;
    chk(bus_rdata == 16'h0, "R2", "unmapped offset", int'(bus_rdata), 0);

    // R9: service during grace prevents the reset request
    do_reset();
    step(1, 8'h40, wval(7'h00, 1, 8'd2), 0);
    step(0, 8'h40, 16'h0, 1);
    step(0, 8'h40, 16'h0, 1);
    chk(nmi == 1'b1, "R7", "nmi before service", int'(nmi), 1);
    step(1, 8'h40, wval(7'h7F, 1, 8'd4), 0);
    chk(nmi == 1'b0, "R9", "nmi cleared", int'(nmi), 0);
    for (int i = 0; i < 3; i++) step(0, 8'h40, 16'h0, 1);
    chk(reset_req == 1'b0, "R9", "no reset after service", int'(reset_req), 0);

    // Random episodes
    for (int ep = 0; ep < 8; ep++) begin
      do_reset();
      for (int n = 0; n < 1500; n++) begin
        int r;
        logic [15:0] d;
        logic [7:0] a;
        bit wr;
        r = int'($urandom_range(0, 99));
        wr = (r < 12);
        a = 8'h40;
        if (r < 2) a = 8'(($urandom_range(0, 15)) * 4);
        d = 16'($urandom);
        if (wr) begin
          if ($urandom_range(0, 9) < 7) d[15:9] = ~m_ctrl[15:9];
          if ($urandom_range(0, 9) < 8) d[7:0] = 8'($urandom_range(0, 6));
          d[8] = ($urandom_range(0, 9) < 8);
        end
        step(wr, a, d, $urandom_range(0, 1) == 1);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule